// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This combinational unit settles which value a fused multiply-add `(a*b)+c` returns when at least one of its three operands is a NaN. It classifies each operand as a quiet NaN, a signaling NaN or a non-NaN value. It then applies one of four selectable priority rule sets and reports the choice as a 2-bit code. The chosen operand is returned quieted. It also raises the invalid-operation flag.

The unit sits beside the multiply-add datapath, which owns the arithmetic. Operands are carried on 64-bit buses. In single precision only the low 32 bits are used and the result is zero-extended. The datapath reports a zero-times-infinity product on `prod_inf_zero`, and some rule sets treat that case specially. When default-NaN mode is on, the result is replaced by the canonical NaN of the precision. The selection and the invalid flag still come from the rules.

Top module: `fma_nan_select`

## Requirements
- R1: Operand classification. In single precision (`is_double`=0) the exponent is bits [30:23] and the quiet bit is bit 22. In double precision the exponent is bits [62:52] and the quiet bit is bit 51. A NaN has an all-ones exponent and a nonzero fraction. A NaN is quiet when its quiet bit is 1 and signaling when that bit is 0.
- R2: `invalid` is 1 whenever any of the three operands is a signaling NaN.
- R3: Rule set 0 (`rule_sel`=0). If `prod_inf_zero` is 1 and c is a quiet NaN, the code is 3 and `invalid` is 1. Otherwise the first match wins, in this order: c signaling (2), a signaling (0), b signaling (1), c quiet (2), a quiet (0). If none matches, the code is 1.
- R4: Rule set 1. If `prod_inf_zero` is 1, the code is 3 and `invalid` is 1. Otherwise the first match wins, in this order: a signaling (0), b signaling (1), c signaling (2), a quiet (0), b quiet (1). If none matches, the code is 2.
- R5: Rule set 2. If `prod_inf_zero` is 1, the code is 2 and `invalid` is 1. Otherwise the code is 0 if a is any NaN, else 2 if c is any NaN, else 1.
- R6: Rule set 3 is the fallback and ignores `prod_inf_zero`. The code is 0 if a is any NaN, else 1 if b is any NaN, else 2.
- R7: For codes 0 to 2, the result is the chosen operand. If that operand is a signaling NaN, its quiet bit is set and every other bit, including the sign and the payload, is kept.
- R8: Code 3 returns the default NaN. In single precision this is 0x7FC00000 and in double precision 0x7FF8000000000000.
- R9: With `dflt_mode`=1, the result is always the default NaN of the precision. `sel_code` and `invalid` are the same as with `dflt_mode`=0.
- R10: In single precision, bits [63:32] of the operands have no effect and bits [63:32] of the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | Multiplicand a |
| op_b | input | 64 | Multiplier b |
| op_c | input | 64 | Addend c |
| is_double | input | 1 | 1 = double precision, 0 = single precision in bits [31:0] |
| prod_inf_zero | input | 1 | Product a*b was zero times infinity |
| dflt_mode | input | 1 | Force the default NaN on the result |
| rule_sel | input | 2 | Rule set select, 0 to 3 |
| res | output | 64 | Resulting NaN |
| invalid | output | 1 | Invalid-operation flag |
| sel_code | output | 2 | 0 = a, 1 = b, 2 = c, 3 = default NaN |

## Verification
The assertions check several properties for every input combination:
- a signaling operand always raises invalid;
- the zero-times-infinity overrides of rule sets 1 and 2 hold;
- code 3 and default-NaN mode produce the canonical pattern;
- a chosen NaN leaves with its quiet bit set;
- single-precision results have a zero upper half.

Only the bench's directed scenarios can show the full priority order of each rule set. They also show the exact payload and sign kept through quieting, that rule set 0's override applies only to a quiet addend, that the fallback ignores the zero-times-infinity flag, and that the upper operand bits are ignored in single precision.

// File: rtl/fnan_pkg.sv
`timescale 1ns/1ps
package fnan_pkg;
  parameter int SP_W     = 32;
  parameter int SP_EXP_W = 8;
  parameter int DP_W     = 64;
  parameter int DP_EXP_W = 11;
  parameter int RULESETS = 4;

  localparam int SP_FRAC_W = SP_W - 1 - SP_EXP_W;
  localparam int DP_FRAC_W = DP_W - 1 - DP_EXP_W;
  localparam int CODE_W    = $clog2(RULESETS);

  localparam logic [SP_W-1:0] DNAN_SP =
    {1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}};
  localparam logic [DP_W-1:0] DNAN_DP =
    {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_e;

  typedef struct packed {
    logic is_nan;
    logic is_q;
    logic is_s;
  } nan_cls_t;

  // Classify a 64-bit bus as a single or double value.
  function automatic nan_cls_t classify(input logic [DP_W-1:0] v, input logic dbl);
    nan_cls_t r;
    logic exp_ones, frac_nz, qbit;
    if (dbl) begin
      exp_ones = &v[DP_W-2 -: DP_EXP_W];
      frac_nz  = |v[DP_FRAC_W-1:0];
      qbit     = v[DP_FRAC_W-1];
    end else begin
      exp_ones = &v[SP_W-2 -: SP_EXP_W];
      frac_nz  = |v[SP_FRAC_W-1:0];
      qbit     = v[SP_FRAC_W-1];
    end
    r.is_nan = exp_ones & frac_nz;
    r.is_q   = r.is_nan & qbit;
    r.is_s   = r.is_nan & ~qbit;
    return r;
  endfunction

  // Set the quiet bit of a signaling NaN; pass everything else through.
  function automatic logic [DP_W-1:0] quieten(input logic [DP_W-1:0] v,
                                              input logic dbl, input logic sig);
    logic [DP_W-1:0] r;
    if (dbl) begin
      r = v;
      if (sig) r[DP_FRAC_W-1] = 1'b1;
    end else begin
      r = {{(DP_W-SP_W){1'b0}}, v[SP_W-1:0]};
      if (sig) r[SP_FRAC_W-1] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [DP_W-1:0] default_nan(input logic dbl);
    return dbl ? DNAN_DP : {{(DP_W-SP_W){1'b0}}, DNAN_SP};
  endfunction
endpackage

// File: rtl/fnan_classify.sv
`timescale 1ns/1ps
module fnan_classify
  import fnan_pkg::*;
(
  input  logic [DP_W-1:0] opnd,
  input  logic            is_double,
  output nan_cls_t        cls
);
  always_comb cls = classify(opnd, is_double);
endmodule

// File: rtl/fnan_rules.sv
`timescale 1ns/1ps
module fnan_rules
  import fnan_pkg::*;
(
  input  nan_cls_t          ca,
  input  nan_cls_t          cb,
  input  nan_cls_t          cc,
  input  logic              infzero,
  input  logic [CODE_W-1:0] rule_sel,
  output logic [1:0]        pick_code,
  output logic              rule_inv
);
  logic [1:0] cand_code [RULESETS];
  logic       cand_inv  [RULESETS];

  for (genvar g = 0; g < RULESETS; g++) begin : g_rule
    if (g == 0) begin : g_r0
      always_comb begin
        cand_inv[g] = 1'b0;
        if (infzero && cc.is_q) begin
          cand_code[g] = PICK_DFLT;
          cand_inv[g]  = 1'b1;
        end
        else if (cc.is_s) cand_code[g] = PICK_C;
        else if (ca.is_s) cand_code[g] = PICK_A;
        else if (cb.is_s) cand_code[g] = PICK_B;
        else if (cc.is_q) cand_code[g] = PICK_C;
        else if (ca.is_q) cand_code[g] = PICK_A;
        else              cand_code[g] = PICK_B;
      end
    end else if (g == 1) begin : g_r1
      always_comb begin
        cand_inv[g] = 1'b0;
        if (infzero) begin
          cand_code[g] = PICK_DFLT;
          cand_inv[g]  = 1'b1;
        end
        else if (ca.is_s) cand_code[g] = PICK_A;
        else if (cb.is_s) cand_code[g] = PICK_B;
        else if (cc.is_s) cand_code[g] = PICK_C;
        else if (ca.is_q) cand_code[g] = PICK_A;
        else if (cb.is_q) cand_code[g] = PICK_B;
        else              cand_code[g] = PICK_C;
      end
    end else if (g == 2) begin : g_r2
      always_comb begin
        cand_inv[g] = 1'b0;
        if (infzero) begin
          cand_code[g] = PICK_C;
          cand_inv[g]  = 1'b1;
        end
        else if (ca.is_nan) cand_code[g] = PICK_A;
        else if (cc.is_nan) cand_code[g] = PICK_C;
        else                cand_code[g] = PICK_B;
      end
    end else begin : g_rfb
      always_comb begin
        cand_inv[g] = 1'b0;
        if (ca.is_nan)      cand_code[g] = PICK_A;
        else if (cb.is_nan) cand_code[g] = PICK_B;
        else                cand_code[g] = PICK_C;
      end
    end
  end

  assign pick_code = cand_code[rule_sel];
  assign rule_inv  = cand_inv[rule_sel];
endmodule

// File: rtl/fnan_emit.sv
`timescale 1ns/1ps
module fnan_emit
  import fnan_pkg::*;
(
  input  logic [DP_W-1:0] op_a,
  input  logic [DP_W-1:0] op_b,
  input  logic [DP_W-1:0] op_c,
  input  nan_cls_t        ca,
  input  nan_cls_t        cb,
  input  nan_cls_t        cc,
  input  logic            is_double,
  input  logic            dflt_mode,
  input  logic [1:0]      pick_code,
  output logic [DP_W-1:0] res,
  output logic            picked_nan,
  output logic            forced_dflt
);
  logic [DP_W-1:0] chosen;

  always_comb begin
    chosen     = default_nan(is_double);
    picked_nan = 1'b0;
    case (pick_code)
      PICK_A: begin chosen = quieten(op_a, is_double, ca.is_s); picked_nan = ca.is_nan; end
      PICK_B: begin chosen = quieten(op_b, is_double, cb.is_s); picked_nan = cb.is_nan; end
      PICK_C: begin chosen = quieten(op_c, is_double, cc.is_s); picked_nan = cc.is_nan; end
      default: ;
    endcase
  end

  assign forced_dflt = dflt_mode | (pick_code == PICK_DFLT);
  assign res = forced_dflt ? default_nan(is_double) : chosen;
endmodule

// File: rtl/fma_nan_select.sv
`timescale 1ns/1ps
module fma_nan_select
  import fnan_pkg::*;
(
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic [63:0] op_c,
  input  logic        is_double,
  input  logic        prod_inf_zero,
  input  logic        dflt_mode,
  input  logic [1:0]  rule_sel,
  output logic [63:0] res,
  output logic        invalid,
  output logic [1:0]  sel_code
);
  localparam int NOPS = 3;

  logic [DP_W-1:0] ops [NOPS];
  nan_cls_t        cls [NOPS];
  logic            any_snan;
  logic            rule_inv;
  logic [1:0]      pick_code;
  logic            picked_nan;
  logic            forced_dflt;

  assign ops[0] = op_a;
  assign ops[1] = op_b;
  assign ops[2] = op_c;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fnan_classify u_cls (.opnd(ops[i]), .is_double(is_double), .cls(cls[i]));
  end

  assign any_snan = cls[0].is_s | cls[1].is_s | cls[2].is_s;

  fnan_rules u_rules (
    .ca(cls[0]), .cb(cls[1]), .cc(cls[2]),
    .infzero(prod_inf_zero), .rule_sel(rule_sel),
    .pick_code(pick_code), .rule_inv(rule_inv)
  );

  fnan_emit u_emit (
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .ca(cls[0]), .cb(cls[1]), .cc(cls[2]),
    .is_double(is_double), .dflt_mode(dflt_mode), .pick_code(pick_code),
    .res(res), .picked_nan(picked_nan), .forced_dflt(forced_dflt)
  );

  assign invalid  = any_snan | rule_inv;
  assign sel_code = pick_code;
endmodule

// File: rtl/fma_nan_select_chk.sv
`timescale 1ns/1ps
module fma_nan_select_chk (
  input logic        is_double,
  input logic        prod_inf_zero,
  input logic        dflt_mode,
  input logic [1:0]  rule_sel,
  input logic [63:0] res,
  input logic        invalid,
  input logic [1:0]  sel_code,
  input logic        any_snan,
  input logic        picked_nan,
  input logic        forced_dflt
);
  logic [63:0] dn;
  assign dn = is_double ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;

  always_comb begin
    assert_snan_invalid_R2: assert (!any_snan || invalid)
      else $error("signaling operand without invalid");
    assert_r1_infzero_R4: assert (!(rule_sel == 2'd1 && prod_inf_zero) || (sel_code == 2'd3 && invalid))
      else $error("rule set 1 zero-times-infinity override");
    assert_r2_infzero_R5: assert (!(rule_sel == 2'd2 && prod_inf_zero) || (sel_code == 2'd2 && invalid))
      else $error("rule set 2 zero-times-infinity override");
    assert_quiet_out_R7: assert (forced_dflt || !picked_nan || (is_double ? res[51] : res[22]))
      else $error("chosen NaN left without quiet bit");
    assert_code3_dnan_R8: assert (sel_code != 2'd3 || res == dn)
      else $error("code 3 without default NaN");
    assert_dflt_mode_R9: assert (!dflt_mode || res == dn)
      else $error("default mode without default NaN");
    assert_single_upper_R10: assert (is_double || res[63:32] == 32'h0)
      else $error("single result has upper bits set");
  end
endmodule

bind fma_nan_select fma_nan_select_chk u_chk (
  .is_double(is_double), .prod_inf_zero(prod_inf_zero), .dflt_mode(dflt_mode),
  .rule_sel(rule_sel), .res(res), .invalid(invalid), .sel_code(sel_code),
  .any_snan(any_snan), .picked_nan(picked_nan), .forced_dflt(forced_dflt)
);

// File: tb/fma_nan_select_test.sv
`timescale 1ns/1ps
module fma_nan_select_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] op_a, op_b, op_c, res;
  logic        is_double, prod_inf_zero, dflt_mode, invalid;
  logic [1:0]  rule_sel, sel_code;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  fma_nan_select uut (.*);

  // single-precision stimulus values
  localparam logic [63:0] ONE = 64'h3F80_0000;
  localparam logic [63:0] QA = 64'hFFC0_00A1, SA = 64'h7F80_00A2, SA_Q = 64'h7FC0_00A2;
  localparam logic [63:0] QB = 64'h7FC0_00B1, SB = 64'hFF80_00B2, SB_Q = 64'hFFC0_00B2;
  localparam logic [63:0] QC = 64'h7FC0_00C1, SC = 64'h7F80_00C2, SC_Q = 64'h7FC0_00C2;
  localparam logic [63:0] DN_S = 64'h7FC0_0000;
  localparam logic [63:0] DN_D = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] ONE_D = 64'h3FF0_0000_0000_0000;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] rs, input logic dbl, input logic iz,
                     input logic dm, input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                     input logic [63:0] eres, input logic einv, input logic [1:0] ecode);
    @(posedge clk);
    rule_sel = rs; is_double = dbl; prod_inf_zero = iz; dflt_mode = dm;
    op_a = a; op_b = b; op_c = c;
    @(negedge clk);
    check(req, "res", res, eres);
    check(req, "invalid", {63'h0, invalid}, {63'h0, einv});
    check(req, "code", {62'h0, sel_code}, {62'h0, ecode});
  endtask

  task automatic t_reset;
    @(negedge clk);
    // all-zero inputs, rule set 0: no NaN, so b is chosen
    check("R3", "reset code", {62'h0, sel_code}, 64'd1);
    check("R2", "reset invalid", {63'h0, invalid}, 64'd0);
    check("R10", "reset res", res, 64'h0);
  endtask

  task automatic t_rule0;
    run("R3", 2'd0, 0, 0, 0, SA, SB, SC, SC_Q, 1, 2'd2);
    run("R3", 2'd0, 0, 0, 0, SA, SB, QC, SA_Q, 1, 2'd0);
    run("R3", 2'd0, 0, 0, 0, QA, SB, ONE, SB_Q, 1, 2'd1);
    run("R3", 2'd0, 0, 0, 0, QA, ONE, QC, QC, 0, 2'd2);
    run("R3", 2'd0, 0, 0, 0, QA, QB, ONE, QA, 0, 2'd0);
    run("R3", 2'd0, 0, 1, 0, ONE, ONE, QC, DN_S, 1, 2'd3);
    run("R3", 2'd0, 0, 1, 0, ONE, ONE, SC, SC_Q, 1, 2'd2);
  endtask

  task automatic t_rule1;
    run("R4", 2'd1, 0, 0, 0, QA, SB, SC, SB_Q, 1, 2'd1);
    run("R4", 2'd1, 0, 0, 0, QA, QB, SC, SC_Q, 1, 2'd2);
    run("R4", 2'd1, 0, 0, 0, ONE, QB, QC, QB, 0, 2'd1);
    run("R4", 2'd1, 0, 1, 0, QA, ONE, QC, DN_S, 1, 2'd3);
  endtask

  task automatic t_rule2;
    run("R5", 2'd2, 0, 0, 0, ONE, QB, QC, QC, 0, 2'd2);
    run("R5", 2'd2, 0, 0, 0, QA, ONE, SC, QA, 1, 2'd0);
    run("R5", 2'd2, 0, 0, 0, ONE, SB, ONE, SB_Q, 1, 2'd1);
    run("R5", 2'd2, 0, 1, 0, QA, ONE, QC, QC, 1, 2'd2);
  endtask

  task automatic t_fallback;
    run("R6", 2'd3, 0, 0, 0, ONE, QB, SC, QB, 1, 2'd1);
    run("R6", 2'd3, 0, 1, 0, ONE, ONE, QC, QC, 0, 2'd2);
    run("R6", 2'd3, 0, 0, 0, SA, QB, QC, SA_Q, 1, 2'd0);
  endtask

  task automatic t_quiet_and_double;
    // R7: payload only in bit 0, quiet bit 22 set, sign kept
    run("R7", 2'd3, 0, 0, 0, 64'hFF80_0001, ONE, ONE, 64'hFFC0_0001, 1, 2'd0);
    // R1/R7 double: quiet bit 51
    run("R1", 2'd0, 1, 0, 0, 64'h7FF0_0000_0000_0001, ONE_D, ONE_D, 64'h7FF8_0000_0000_0001, 1, 2'd0);
    // R1: single NaN pattern zero-extended is not a double NaN -> rule 3 picks c
    run("R1", 2'd3, 1, 0, 0, QA, ONE_D, ONE_D, ONE_D, 0, 2'd2);
    run("R8", 2'd1, 1, 1, 0, ONE_D, ONE_D, 64'h7FF8_0000_0000_00C1, DN_D, 1, 2'd3);
  endtask

  task automatic t_single_upper;
    run("R10", 2'd3, 0, 0, 0, {32'hDEAD_BEEF, QA[31:0]}, ONE, ONE, QA, 0, 2'd0);
    // double NaN only in the upper half: not a NaN in single mode
    run("R10", 2'd3, 0, 0, 0, 64'h7FF8_0000_0000_0000, {32'hFFFF_FFFF, QB[31:0]}, ONE, QB, 0, 2'd1);
  endtask

  task automatic t_default_mode;
    run("R9", 2'd0, 0, 0, 1, SA, ONE, ONE, DN_S, 1, 2'd0);
    run("R9", 2'd2, 1, 1, 1, ONE_D, ONE_D, 64'h7FF8_0000_0000_00C1, DN_D, 1, 2'd2);
    run("R9", 2'd3, 0, 0, 1, ONE, QB, ONE, DN_S, 0, 2'd1);
  endtask

  initial begin
    op_a = '0; op_b = '0; op_c = '0;
    is_double = 0; prod_inf_zero = 0; dflt_mode = 0; rule_sel = 2'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rule0();
    t_rule1();
    t_rule2();
    t_fallback();
    t_quiet_and_double();
    t_single_upper();
    t_default_mode();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule